// File: doc/BRIEF.md
# Timer Host Register Interface

This block sits between an 8-bit CPU bus and a set of 16-bit counter channels. It decodes a two-bit address into one counter port per channel plus a control port, and keeps for each channel the byte format of its reads and loads, its operating mode and its count encoding. Count values arrive one byte at a time. The block assembles them into 16-bit loads and hands each load to its channel with strobes. The counting itself lives in the channels, which supply their live counts back to this block.

Reads return the count one byte at a time in the channel's format. A snapshot command written to the control port freezes a copy of a channel's live count. Reads then return that copy until it has been read out completely, and after that they return the live count again. The bus is synchronous: every clock cycle in which chip select and exactly one of the two strobes are low counts as one byte access. The read byte is valid during that same cycle, together with an output-enable that controls the external data driver.

Top module: `tmr_host_if`

## Requirements
- R1: An access needs csN low and exactly one of rdN and wrN low. Addresses 0 to NUM_CH-1 select the counter ports and address 3 selects the control port. dataOe is high only during a read of a counter port. While csN is high, dataOe stays low and no channel state or strobe changes.
- R2: A control word carries the channel select in bits 7:6, the format in bits 5:4, the mode in bits 3:1 (shown on chMode) and the count encoding in bit 0 (shown on chBcd, 1 = decimal). A word whose select is 3 is ignored.
- R3: A control word with a nonzero format raises that channel's chCtrlStb for exactly the next cycle. It returns the channel's write and read byte toggles to the low byte and drops any snapshot the channel holds.
- R4: In format 01, each counter write loads {8'h00, byte} and pulses chLoadStb in the next cycle.
- R5: In format 10, each counter write loads {byte, 8'h00} and pulses chLoadStb in the next cycle.
- R6: In format 11, the first write to a channel pulses chFirstStb. The second write pulses chLoadStb and loads {second, first}. Each channel keeps its own toggle, so byte pairs to different channels may be interleaved.
- R7: A read returns the low byte in format 01 and the high byte in format 10. In format 11, successive reads alternate low, high, low.
- R8: A control word with format 00 snapshots that channel's live count in the cycle it is written. Reads return the snapshot until it has been read out fully in the channel's format, and then return the live count.
- R9: A snapshot command to a channel that already holds an unread snapshot is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| addr | input | 2 | Port address |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data |
| dataOe | output | 1 | Read data enable for the external driver |
| liveCount | input | NUM_CH*16 | Live count of each channel |
| chMode | output | NUM_CH*3 | Mode field of each channel |
| chBcd | output | NUM_CH | Decimal count select of each channel |
| chCtrlStb | output | NUM_CH | Control word written pulse |
| chFirstStb | output | NUM_CH | First byte of a two-byte load pulse |
| chLoadStb | output | NUM_CH | Full count loaded pulse |
| chLoadVal | output | NUM_CH*16 | Assembled count for each channel |

## Verification
The bench builds the block with the default of three channels. With that setting the control port shares the address space with no counter, and a select value of 3 is an illegal control word rather than a fourth channel. The two-byte tests interleave low and high bytes across two channels to show that each channel keeps its own toggle. The snapshot tests change the live count between bytes, so that a snapshot read can be told apart from a live read.

// File: rtl/tmr_host_pkg.sv
package tmr_host_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef struct packed {
    logic              ctrlWr;    // control word with nonzero format
    logic              latchReq;  // control word with format 00
    logic              cntWr;     // byte written to a counter port
    logic              cntRd;     // byte read from a counter port
    logic [1:0]        chan;      // target channel
    logic [BYTE_W-1:0] wrByte;    // bus byte
  } hostOp_t;
endpackage

// File: rtl/tmr_host_ctrl.sv
module tmr_host_ctrl
  import tmr_host_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     csN,
  input  logic                     rdN,
  input  logic                     wrN,
  input  logic [1:0]               addr,
  input  logic [BYTE_W-1:0]        dataIn,
  input  logic [NUM_CH*BYTE_W-1:0] rdBytes,
  output hostOp_t                  op,
  output logic [BYTE_W-1:0]        dataOut,
  output logic                     dataOe
);
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic rdAct, wrAct, isCtrl, isCnt, wordOk;
  logic [1:0] wordSel;
  logic [BYTE_W-1:0] selByte;

  always_comb begin
    rdAct   = !csN && !rdN && wrN;
    wrAct   = !csN && !wrN && rdN;
    isCtrl  = (addr == CTRL_ADDR);
    isCnt   = (32'(addr) < NUM_CH) && !isCtrl;
    wordSel = dataIn[7:6];
    wordOk  = (32'(wordSel) < NUM_CH);

    op.ctrlWr   = wrAct && isCtrl && wordOk && (dataIn[5:4] != 2'b00);
    op.latchReq = wrAct && isCtrl && wordOk && (dataIn[5:4] == 2'b00);
    op.cntWr    = wrAct && isCnt;
    op.cntRd    = rdAct && isCnt;
    op.chan     = isCtrl ? wordSel : addr;
    op.wrByte   = dataIn;

    selByte = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (32'(addr) == i) selByte = rdBytes[i*BYTE_W +: BYTE_W];
    end
    dataOe  = op.cntRd;
    dataOut = dataOe ? selByte : '0;
  end

  // R1
  op_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({op.ctrlWr, op.latchReq, op.cntWr, op.cntRd}));
endmodule

// File: rtl/tmr_host_chan.sv
module tmr_host_chan
  import tmr_host_pkg::*;
#(
  parameter int CH_IDX = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostOp_t           op,
  input  logic [CNT_W-1:0]  liveCount,
  output logic [BYTE_W-1:0] rdByte,
  output logic [2:0]        mode,
  output logic              bcd,
  output logic              ctrlStb,
  output logic              firstStb,
  output logic              loadStb,
  output logic [CNT_W-1:0]  loadVal
);
  localparam logic [1:0] FMT_LO   = 2'b01;
  localparam logic [1:0] FMT_HI   = 2'b10;
  localparam logic [1:0] FMT_PAIR = 2'b11;

  logic [1:0]        fmt;
  logic              wrHigh, rdHigh, latched;
  logic [CNT_W-1:0]  latchVal, src;
  logic [BYTE_W-1:0] lowHold;
  logic              hit, anyOp;

  assign hit   = (op.chan == 2'(CH_IDX));
  assign anyOp = hit && (op.ctrlWr || op.latchReq || op.cntWr || op.cntRd);
  assign src   = latched ? latchVal : liveCount;

  always_comb begin
    case (fmt)
      FMT_HI:   rdByte = src[CNT_W-1:BYTE_W];
      FMT_PAIR: rdByte = rdHigh ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
      default:  rdByte = src[BYTE_W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fmt <= FMT_PAIR; mode <= '0; bcd <= 1'b0;
      wrHigh <= 1'b0; rdHigh <= 1'b0; latched <= 1'b0;
      latchVal <= '0; lowHold <= '0; loadVal <= '0;
      ctrlStb <= 1'b0; firstStb <= 1'b0; loadStb <= 1'b0;
    end else begin
      ctrlStb  <= 1'b0;
      firstStb <= 1'b0;
      loadStb  <= 1'b0;
      if (hit && op.ctrlWr) begin
        fmt     <= op.wrByte[5:4];
        mode    <= op.wrByte[3:1];
        bcd     <= op.wrByte[0];
        wrHigh  <= 1'b0;
        rdHigh  <= 1'b0;
        latched <= 1'b0;
        ctrlStb <= 1'b1;
      end else if (hit && op.latchReq && !latched) begin
        latched  <= 1'b1;
        latchVal <= liveCount;
      end else if (hit && op.cntWr) begin
        case (fmt)
          FMT_LO: begin
            loadVal <= {{BYTE_W{1'b0}}, op.wrByte};
            loadStb <= 1'b1;
          end
          FMT_HI: begin
            loadVal <= {op.wrByte, {BYTE_W{1'b0}}};
            loadStb <= 1'b1;
          end
          default: begin
            if (!wrHigh) begin
              lowHold  <= op.wrByte;
              wrHigh   <= 1'b1;
              firstStb <= 1'b1;
            end else begin
              loadVal <= {op.wrByte, lowHold};
              wrHigh  <= 1'b0;
              loadStb <= 1'b1;
            end
          end
        endcase
      end else if (hit && op.cntRd) begin
        if (fmt == FMT_PAIR) begin
          rdHigh <= !rdHigh;
          if (rdHigh) latched <= 1'b0;
        end else begin
          latched <= 1'b0;
        end
      end
    end
  end

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !anyOp |=> ($stable(wrHigh) && $stable(rdHigh) && $stable(latched) && $stable(fmt)));
  // R3
  ctrl_rearm_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb |-> (!wrHigh && !rdHigh && !latched));
  // R5
  hi_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && fmt == FMT_HI) |-> (loadVal[BYTE_W-1:0] == '0));
  // R6
  load_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |-> $past(hit && op.cntWr));
  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (latched && hit && op.latchReq) |=> $stable(latchVal));
endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
  import tmr_host_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    csN,
  input  logic                    rdN,
  input  logic                    wrN,
  input  logic [1:0]              addr,
  input  logic [7:0]              dataIn,
  output logic [7:0]              dataOut,
  output logic                    dataOe,
  input  logic [NUM_CH*16-1:0]    liveCount,
  output logic [NUM_CH*3-1:0]     chMode,
  output logic [NUM_CH-1:0]       chBcd,
  output logic [NUM_CH-1:0]       chCtrlStb,
  output logic [NUM_CH-1:0]       chFirstStb,
  output logic [NUM_CH-1:0]       chLoadStb,
  output logic [NUM_CH*16-1:0]    chLoadVal
);
  hostOp_t op;
  logic [NUM_CH*BYTE_W-1:0] rdBytes;

  tmr_host_ctrl #(.NUM_CH(NUM_CH)) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .addr(addr), .dataIn(dataIn), .rdBytes(rdBytes),
    .op(op), .dataOut(dataOut), .dataOe(dataOe)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    tmr_host_chan #(.CH_IDX(g)) chan_i (
      .clk(clk), .rstN(rstN), .op(op),
      .liveCount(liveCount[g*CNT_W +: CNT_W]),
      .rdByte(rdBytes[g*BYTE_W +: BYTE_W]),
      .mode(chMode[g*3 +: 3]),
      .bcd(chBcd[g]),
      .ctrlStb(chCtrlStb[g]),
      .firstStb(chFirstStb[g]),
      .loadStb(chLoadStb[g]),
      .loadVal(chLoadVal[g*CNT_W +: CNT_W])
    );
  end
endmodule

// File: tb/tmr_host_if_tb_top.sv
module tmr_host_if_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic dataOe;
  logic [NCH*16-1:0] liveCount = '0;
  logic [NCH*3-1:0] chMode;
  logic [NCH-1:0] chBcd, chCtrlStb, chFirstStb, chLoadStb;
  logic [NCH*16-1:0] chLoadVal;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [NCH-1:0] sCtrl, sFirst, sLoad;
  logic [NCH*16-1:0] sVal;
  logic [7:0] rByte;
  logic rOe;

  tmr_host_if #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .liveCount(liveCount), .chMode(chMode), .chBcd(chBcd),
    .chCtrlStb(chCtrlStb), .chFirstStb(chFirstStb),
    .chLoadStb(chLoadStb), .chLoadVal(chLoadVal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d, input bit sel = 1'b1);
    @(negedge clk);
    csN = !sel; wrN = 1'b0; addr = a; dataIn = d;
    @(negedge clk);
    csN = 1'b1; wrN = 1'b1;
    sCtrl = chCtrlStb; sFirst = chFirstStb; sLoad = chLoadStb; sVal = chLoadVal;
  endtask

  task automatic busRead(input logic [1:0] a, input bit sel = 1'b1);
    @(negedge clk);
    csN = !sel; rdN = 1'b0; addr = a;
    #1;
    rByte = dataOut; rOe = dataOe;
    @(negedge clk);
    csN = 1'b1; rdN = 1'b1;
  endtask

  task automatic testReset();
    checkEq("R1 reset dataOe", 32'(dataOe), 0);
    checkEq("R1 reset strobes", 32'({chCtrlStb, chFirstStb, chLoadStb}), 0);
    checkEq("R1 reset loadVal", 32'(chLoadVal[31:0]), 0);
  endtask

  task automatic testCtrlWord();
    busWrite(2'd3, 8'h75);  // ch1, fmt 11, mode 2, decimal
    checkEq("R3 ctrl strobe ch1", 32'(sCtrl), 32'b010);
    checkEq("R2 mode ch1", 32'(chMode[5:3]), 2);
    checkEq("R2 bcd ch1", 32'(chBcd[1]), 1);
    busWrite(2'd3, 8'hF6);  // select 3: ignored
    checkEq("R2 illegal select strobe", 32'(sCtrl), 0);
    checkEq("R2 illegal select mode kept", 32'(chMode[5:3]), 2);
  endtask

  task automatic testLowOnly();
    busWrite(2'd3, 8'h10);
    busWrite(2'd0, 8'h34);
    checkEq("R4 low-only load strobe", 32'(sLoad), 32'b001);
    checkEq("R4 low-only value", 32'(sVal[15:0]), 32'h0034);
  endtask

  task automatic testHighOnly();
    busWrite(2'd3, 8'hA2);
    checkEq("R2 mode ch2", 32'(chMode[8:6]), 1);
    busWrite(2'd2, 8'hAA);
    checkEq("R5 high-only load strobe", 32'(sLoad), 32'b100);
    checkEq("R5 high-only value", 32'(sVal[47:32]), 32'hAA00);
  endtask

  task automatic testPairInterleave();
    busWrite(2'd3, 8'h30);
    busWrite(2'd3, 8'h70);
    busWrite(2'd0, 8'h34);
    checkEq("R6 first byte ch0", 32'({sFirst, sLoad}), 32'b001_000);
    busWrite(2'd1, 8'h78);
    checkEq("R6 first byte ch1", 32'({sFirst, sLoad}), 32'b010_000);
    busWrite(2'd0, 8'h12);
    checkEq("R6 full load ch0", 32'({sFirst, sLoad}), 32'b000_001);
    checkEq("R6 value ch0", 32'(sVal[15:0]), 32'h1234);
    busWrite(2'd1, 8'h56);
    checkEq("R6 full load ch1", 32'({sFirst, sLoad}), 32'b000_010);
    checkEq("R6 value ch1", 32'(sVal[31:16]), 32'h5678);
  endtask

  task automatic testReadFormats();
    liveCount[15:0] = 16'hBEEF;
    busWrite(2'd3, 8'h10);
    busRead(2'd0);
    checkEq("R7 low-only read", 32'({rOe, rByte}), 32'h1EF);
    busWrite(2'd3, 8'h20);
    busRead(2'd0);
    checkEq("R7 high-only read", 32'({rOe, rByte}), 32'h1BE);
    busWrite(2'd3, 8'h30);
    busRead(2'd0);
    checkEq("R7 pair read 1", 32'(rByte), 32'hEF);
    busRead(2'd0);
    checkEq("R7 pair read 2", 32'(rByte), 32'hBE);
    busRead(2'd0);
    checkEq("R7 pair read 3", 32'(rByte), 32'hEF);
  endtask

  task automatic testLatch();
    busWrite(2'd3, 8'h70);
    liveCount[31:16] = 16'h1357;
    busWrite(2'd3, 8'h40);
    checkEq("R8 latch gives no ctrl strobe", 32'(sCtrl), 0);
    liveCount[31:16] = 16'h2468;
    busWrite(2'd3, 8'h40);  // ignored: snapshot still unread
    liveCount[31:16] = 16'h9ABC;
    busRead(2'd1);
    checkEq("R8 snapshot low", 32'(rByte), 32'h57);
    busRead(2'd1);
    checkEq("R9 snapshot high kept", 32'(rByte), 32'h13);
    busRead(2'd1);
    checkEq("R8 live after snapshot", 32'(rByte), 32'hBC);
    busRead(2'd1);
    checkEq("R8 live high", 32'(rByte), 32'h9A);
  endtask

  task automatic testRearm();
    busWrite(2'd3, 8'h30);
    busWrite(2'd0, 8'h11);
    busWrite(2'd3, 8'h30);
    busWrite(2'd0, 8'h22);
    checkEq("R3 write toggle rearmed", 32'({sFirst[0], sLoad[0]}), 32'b10);
    busRead(2'd0);
    busWrite(2'd3, 8'h30);
    busRead(2'd0);
    checkEq("R3 read toggle rearmed", 32'(rByte), 32'hEF);
    liveCount[31:16] = 16'h4321;
    busWrite(2'd3, 8'h40);
    liveCount[31:16] = 16'h8765;
    busRead(2'd1);
    busWrite(2'd3, 8'h70);
    busRead(2'd1);
    checkEq("R3 snapshot dropped", 32'(rByte), 32'h65);
  endtask

  task automatic testDeselect();
    busWrite(2'd3, 8'h30);
    busRead(2'd0, 1'b0);
    checkEq("R1 deselected read oe", 32'(rOe), 0);
    busWrite(2'd3, 8'h10, 1'b0);
    checkEq("R1 deselected ctrl strobe", 32'(sCtrl), 0);
    busWrite(2'd0, 8'h55, 1'b0);
    checkEq("R1 deselected write strobes", 32'({sFirst, sLoad}), 0);
    busRead(2'd0);
    checkEq("R1 format and toggle kept", 32'(rByte), 32'hEF);
    busRead(2'd3);
    checkEq("R1 control port read oe", 32'(rOe), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testCtrlWord();
    testLowOnly();
    testHighOnly();
    testPairInterleave();
    testReadFormats();
    testLatch();
    testRearm();
    testDeselect();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule